// File: doc/BRIEF.md
# Configuration Register Unlock Detector

This block sits on the device side of an asynchronous 16-bit pseudo-static memory. It watches the stream of completed array operations. Each operation arrives as a single-cycle strobe with its type, its 22-bit word address, its data and a flag that says whether a write was framed by the chip-enable strobe. Reaching the device's two configuration registers needs no dedicated enable pin. Software uses an in-band pattern instead: two reads of the top word address, then two writes to the same address.

The data of the first write picks the target register: the refresh configuration register or the bus configuration register. The fourth operation then moves a full 16-bit word. If it is a write, the word loads the selected register. If it is a read, the register contents come back on a read-back bus. A third consecutive read of the top address locks the detector out. The lockout lasts until a read of any other address is seen. The pattern operations still reach the array, so the word stored at the top address can change. That is a concern of the array, not of this block.

The refresh register holds the deep power-down control bit at position 4. A load made through the pattern never changes that bit, so the pattern cannot enter or leave deep power-down.

Top module: `cfg_unlock_detector`

## Requirements
- R1: After reset the refresh register reads 0x0010, the bus register reads 0x9D1F, and cfg_hit and cfg_load are low.
- R2: The sequence read, read, write 0x0000, write D, all at address 0x3FFFFF with the writes chip-enable-controlled, loads D into the refresh register. In the cycle after the fourth operation, cfg_hit and cfg_load are high, cfg_sel is 0, and cfg_load_data shows the stored value.
- R3: The same sequence with a selector write of 0x0001 loads the bus register with D, and cfg_sel is 1 (1 means bus, 0 means refresh).
- R4: When the fourth operation is a read of 0x3FFFFF, cfg_hit rises with cfg_load low, cfg_rdata carries the selected register's contents, and neither register changes.
- R5: A third consecutive read of 0x3FFFFF locks the detector out. While locked out, no operation at 0x3FFFFF gives an access. A read of any other address ends the lockout, and the next full pattern then works.
- R6: A selector write with op_ce_ctrl low (controlled by the write-enable strobe) does not advance the pattern, and the following write gives no access.
- R7: A selector value other than 0x0000 or 0x0001 aborts the pattern without any register access.
- R8: An operation at any address other than 0x3FFFFF, or an operation of the wrong type for its step, returns the detector to idle. A fresh pattern afterwards works.
- R9: A load of the refresh register through the pattern keeps bit 4 (the deep power-down control) at its previous value and loads all other bits from D.
- R10: cfg_hit and cfg_load are single-cycle pulses. The registers change only in a cycle in which cfg_load is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe marking a completed array operation |
| op_write | input | 1 | 1 = write, 0 = read |
| op_addr | input | 22 | Word address of the operation |
| op_wdata | input | 16 | Write data of the operation |
| op_ce_ctrl | input | 1 | Write was framed by the chip-enable strobe |
| cfg_hit | output | 1 | Pulse: the fourth operation reached a configuration register |
| cfg_load | output | 1 | Pulse: the access was a load |
| cfg_sel | output | 1 | Target of the last access: 0 refresh, 1 bus |
| cfg_load_data | output | 16 | Value stored by the last load |
| cfg_rdata | output | 16 | Contents returned by the last read access |
| rfr_cfg | output | 16 | Current refresh configuration register |
| bus_cfg | output | 16 | Current bus configuration register |

## Verification
The main function is driven with a complete load pattern for each register, with a read-back pattern for each register, and with a refresh load whose data clears the power-down bit. Together these separate a correct target decode from a swapped one, and a masked load from an unmasked one. Broken patterns are also applied: a third read, a write-enable-controlled selector, an out-of-range selector, a foreign address and an out-of-order type. Each must give no access and leave both registers unchanged, and a fresh pattern afterwards must still work. This tells a correct reset-to-idle apart from leftover state. The lockout is held under further top-address traffic and then released by a foreign read, which shows that only that specific operation clears it.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD1  = 3'd1,
      ST_RD2  = 3'd2,
      ST_SEL  = 3'd3,
      ST_LOCK = 3'd4
   } seq_state_e;

   typedef enum logic {
      TGT_RFR = 1'b0,
      TGT_BUS = 1'b1
   } cfg_tgt_e;

   typedef struct packed {
      logic     hit;
      logic     write;
      cfg_tgt_e tgt;
   } cfg_acc_t;

endpackage

// File: rtl/cfgu_addr_match.sv
module cfgu_addr_match #(
   parameter int ADDR_W = 22,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              is_top
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

   logic match_c;
   assign match_c = (addr == TOP_ADDR);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) is_top <= 1'b0;
            else        is_top <= match_c;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign is_top = match_c;
      end
   endgenerate
endmodule

// File: rtl/cfgu_seq_fsm.sv
module cfgu_seq_fsm
   import cfgu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_write,
   input  logic              is_top,
   input  logic              op_ce_ctrl,
   input  logic [DATA_W-1:0] op_wdata,
   output cfg_acc_t          acc
);
   seq_state_e st_q, st_d;
   cfg_tgt_e   tgt_q;
   logic       sel_ok;
   logic       top_rd, top_wr, other_rd;

   assign sel_ok   = (op_wdata[DATA_W-1:1] == '0);
   assign top_rd   = op_valid && !op_write && is_top;
   assign top_wr   = op_valid &&  op_write && is_top;
   assign other_rd = op_valid && !op_write && !is_top;

   always_comb begin
      st_d      = st_q;
      acc.hit   = 1'b0;
      acc.write = 1'b0;
      acc.tgt   = tgt_q;
      if (op_valid) begin
         unique case (st_q)
            ST_IDLE: st_d = top_rd ? ST_RD1 : ST_IDLE;
            ST_RD1:  st_d = top_rd ? ST_RD2 : ST_IDLE;
            ST_RD2: begin
               if (top_rd)
                  st_d = ST_LOCK;
               else if (top_wr && op_ce_ctrl && sel_ok)
                  st_d = ST_SEL;
               else
                  st_d = ST_IDLE;
            end
            ST_SEL: begin
               st_d = ST_IDLE;
               if (is_top) begin
                  acc.hit   = 1'b1;
                  acc.write = op_write;
               end
            end
            ST_LOCK: st_d = other_rd ? ST_IDLE : ST_LOCK;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         tgt_q <= TGT_RFR;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RD2 && st_d == ST_SEL)
            tgt_q <= cfg_tgt_e'(op_wdata[0]);
      end
   end
endmodule

// File: rtl/cfgu_cfg_regs.sv
module cfgu_cfg_regs
   import cfgu_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] RFR_RST  = 16'h0010,
   parameter logic [DATA_W-1:0] BUS_RST  = 16'h9D1F,
   parameter int                DPD_BIT  = 4,
   parameter bit                KEEP_DPD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  cfg_tgt_e          ld_tgt,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] ld_value,
   output logic [DATA_W-1:0] rfr_q,
   output logic [DATA_W-1:0] bus_q
);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << DPD_BIT;

   logic [DATA_W-1:0] rfr_next;

   generate
      if (KEEP_DPD) begin : g_keep
         assign rfr_next = (ld_data & ~KEEP_MASK) | (rfr_q & KEEP_MASK);
      end else begin : g_full
         assign rfr_next = ld_data;
      end
   endgenerate

   assign ld_value = (ld_tgt == TGT_BUS) ? ld_data : rfr_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rfr_q <= RFR_RST;
         bus_q <= BUS_RST;
      end else if (ld_en) begin
         if (ld_tgt == TGT_BUS) bus_q <= ld_data;
         else                   rfr_q <= rfr_next;
      end
   end
endmodule

// File: rtl/cfg_unlock_detector.sv
module cfg_unlock_detector
   import cfgu_pkg::*;
#(
   parameter int                ADDR_W   = 22,
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] RFR_RST  = 16'h0010,
   parameter logic [DATA_W-1:0] BUS_RST  = 16'h9D1F,
   parameter int                DPD_BIT  = 4,
   parameter bit                KEEP_DPD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_write,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic              op_ce_ctrl,
   output logic              cfg_hit,
   output logic              cfg_load,
   output logic              cfg_sel,
   output logic [DATA_W-1:0] cfg_load_data,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [DATA_W-1:0] rfr_cfg,
   output logic [DATA_W-1:0] bus_cfg
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("ADDR_W must be at least 1");
      end
      if (DPD_BIT < 0 || DPD_BIT >= DATA_W) begin : g_bad_dpd
         $error("DPD_BIT must lie inside the data word");
      end
   endgenerate

   logic              is_top;
   cfg_acc_t          acc;
   logic              ld_en;
   logic [DATA_W-1:0] ld_value;

   cfgu_addr_match #(.ADDR_W(ADDR_W), .REG_OUT(1'b0)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (op_addr),
      .is_top (is_top)
   );

   cfgu_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid   (op_valid),
      .op_write   (op_write),
      .is_top     (is_top),
      .op_ce_ctrl (op_ce_ctrl),
      .op_wdata   (op_wdata),
      .acc        (acc)
   );

   assign ld_en = acc.hit && acc.write;

   cfgu_cfg_regs #(
      .DATA_W   (DATA_W),
      .RFR_RST  (RFR_RST),
      .BUS_RST  (BUS_RST),
      .DPD_BIT  (DPD_BIT),
      .KEEP_DPD (KEEP_DPD)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_tgt   (acc.tgt),
      .ld_data  (op_wdata),
      .ld_value (ld_value),
      .rfr_q    (rfr_cfg),
      .bus_q    (bus_cfg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_hit       <= 1'b0;
         cfg_load      <= 1'b0;
         cfg_sel       <= 1'b0;
         cfg_load_data <= '0;
         cfg_rdata     <= '0;
      end else begin
         cfg_hit  <= acc.hit;
         cfg_load <= ld_en;
         if (acc.hit)
            cfg_sel <= acc.tgt;
         if (ld_en)
            cfg_load_data <= ld_value;
         if (acc.hit && !acc.write)
            cfg_rdata <= (acc.tgt == TGT_BUS) ? bus_cfg : rfr_cfg;
      end
   end
endmodule

// File: rtl/cfgu_checker.sv
module cfgu_checker #(
   parameter int DATA_W   = 16,
   parameter int DPD_BIT  = 4,
   parameter bit KEEP_DPD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              cfg_hit,
   input logic              cfg_load,
   input logic              cfg_sel,
   input logic [DATA_W-1:0] cfg_load_data,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic [DATA_W-1:0] rfr_cfg,
   input logic [DATA_W-1:0] bus_cfg
);
   p_load_has_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> cfg_hit);

   p_load_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> cfg_load_data == (cfg_sel ? bus_cfg : rfr_cfg));

   p_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hit && !cfg_load) |-> cfg_rdata == (cfg_sel ? bus_cfg : rfr_cfg));

   p_hit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> !cfg_hit);

   p_hit_after_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |-> $past(op_valid));

   p_regs_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(rfr_cfg) || !$stable(bus_cfg)) |-> cfg_load);

   generate
      if (KEEP_DPD) begin : g_dpd_chk
         p_dpd_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(rfr_cfg[DPD_BIT]));
      end
   endgenerate
endmodule

bind cfg_unlock_detector cfgu_checker #(
   .DATA_W   (DATA_W),
   .DPD_BIT  (DPD_BIT),
   .KEEP_DPD (KEEP_DPD)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .cfg_hit       (cfg_hit),
   .cfg_load      (cfg_load),
   .cfg_sel       (cfg_sel),
   .cfg_load_data (cfg_load_data),
   .cfg_rdata     (cfg_rdata),
   .rfr_cfg       (rfr_cfg),
   .bus_cfg       (bus_cfg)
);

// File: tb/tb_cfg_unlock_detector.sv
`timescale 1ns/1ps
module tb_cfg_unlock_detector;
   localparam logic [21:0] TOP   = 22'h3FFFFF;
   localparam logic [21:0] OTHER = 22'h000123;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_write = 1'b0, op_ce_ctrl = 1'b0;
   logic [21:0] op_addr = '0;
   logic [15:0] op_wdata = '0;
   logic        cfg_hit, cfg_load, cfg_sel;
   logic [15:0] cfg_load_data, cfg_rdata, rfr_cfg, bus_cfg;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] exp_rfr = 16'h0010;
   logic [15:0] exp_bus = 16'h9D1F;

   always #2.5 clk = ~clk;

   cfg_unlock_detector dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
      .op_addr(op_addr), .op_wdata(op_wdata), .op_ce_ctrl(op_ce_ctrl),
      .cfg_hit(cfg_hit), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
      .cfg_load_data(cfg_load_data), .cfg_rdata(cfg_rdata),
      .rfr_cfg(rfr_cfg), .bus_cfg(bus_cfg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one operation; outputs sampled one cycle after it is consumed
   task automatic op(input logic w, input logic [21:0] a, input logic [15:0] d,
                     input logic ce, input logic exp_hit, input string tag);
      @(negedge clk);
      op_valid = 1'b1; op_write = w; op_addr = a; op_wdata = d; op_ce_ctrl = ce;
      @(negedge clk);
      op_valid = 1'b0;
      chk({tag, " hit"}, cfg_hit, exp_hit);
   endtask

   task automatic regs_chk(input string tag);
      chk({tag, " rfr"}, rfr_cfg, exp_rfr);
      chk({tag, " bus"}, bus_cfg, exp_bus);
   endtask

   function automatic logic [15:0] rfr_merge(input logic [15:0] d);
      return (d & 16'hFFEF) | (exp_rfr & 16'h0010);
   endfunction

   task automatic load_pattern(input logic [15:0] sel, input logic [15:0] d, input string tag);
      logic [15:0] val;
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, tag);
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, tag);
      op(1'b1, TOP, sel,   1'b1, 1'b0, tag);
      op(1'b1, TOP, d,     1'b1, 1'b1, tag);
      val = sel[0] ? d : rfr_merge(d);
      if (sel[0]) exp_bus = val; else exp_rfr = val;
      chk({tag, " load"}, cfg_load, 1'b1);
      chk({tag, " sel"}, cfg_sel, sel[0]);
      chk({tag, " load_data"}, cfg_load_data, val);
      regs_chk(tag);
   endtask

   task automatic t_reset_r1();
      chk("R1 hit", cfg_hit, 1'b0);
      chk("R1 load", cfg_load, 1'b0);
      regs_chk("R1");
   endtask

   task automatic t_load_rfr_r2();
      load_pattern(16'h0000, 16'h1203, "R2");
      chk("R2 rfr value", rfr_cfg, 16'h1213);
   endtask

   task automatic t_load_bus_r3();
      load_pattern(16'h0001, 16'hA5C3, "R3");
      chk("R3 bus value", bus_cfg, 16'hA5C3);
   endtask

   task automatic t_read_back_r4();
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R4");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R4");
      op(1'b1, TOP, 16'h0001, 1'b1, 1'b0, "R4");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b1, "R4 bus read");
      chk("R4 load low", cfg_load, 1'b0);
      chk("R4 sel bus", cfg_sel, 1'b1);
      chk("R4 rdata bus", cfg_rdata, exp_bus);
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R4");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R4");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R4");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b1, "R4 rfr read");
      chk("R4 sel rfr", cfg_sel, 1'b0);
      chk("R4 rdata rfr", cfg_rdata, exp_rfr);
      regs_chk("R4 unchanged");
   endtask

   task automatic t_dpd_r9();
      load_pattern(16'h0000, 16'hFFEF, "R9");
      chk("R9 dpd bit kept", rfr_cfg[4], 1'b1);
      chk("R9 rfr value", rfr_cfg, 16'hFFFF);
   endtask

   task automatic t_lockout_r5();
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5 third read");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R5 locked");
      op(1'b1, TOP, 16'h5555, 1'b1, 1'b0, "R5 locked");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5 locked");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5 locked");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R5 locked");
      op(1'b1, TOP, 16'h6666, 1'b1, 1'b0, "R5 locked");
      op(1'b1, OTHER, 16'h0, 1'b1, 1'b0, "R5 write other keeps lock");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5 locked");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R5 locked");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R5 locked");
      op(1'b1, TOP, 16'h7777, 1'b1, 1'b0, "R5 locked");
      regs_chk("R5 locked");
      op(1'b0, OTHER, 16'h0, 1'b0, 1'b0, "R5 release");
      load_pattern(16'h0000, 16'h0030, "R5 after release");
   endtask

   task automatic t_we_ctrl_r6();
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R6");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R6");
      op(1'b1, TOP, 16'h0001, 1'b0, 1'b0, "R6 we-controlled");
      op(1'b1, TOP, 16'h0F0F, 1'b1, 1'b0, "R6 no access");
      regs_chk("R6");
      load_pattern(16'h0001, 16'h0F0F, "R6 fresh");
   endtask

   task automatic t_bad_sel_r7();
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R7");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R7");
      op(1'b1, TOP, 16'h0002, 1'b1, 1'b0, "R7 sel 2");
      op(1'b1, TOP, 16'h4444, 1'b1, 1'b0, "R7 no access");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R7");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R7");
      op(1'b1, TOP, 16'h8001, 1'b1, 1'b0, "R7 sel 8001");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R7 no access");
      regs_chk("R7");
   endtask

   task automatic t_other_r8();
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R8");
      op(1'b0, OTHER, 16'h0, 1'b0, 1'b0, "R8 foreign read");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R8");
      op(1'b1, TOP, 16'h2222, 1'b1, 1'b0, "R8 no access");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R8");
      op(1'b1, TOP, 16'h0000, 1'b1, 1'b0, "R8 early write");
      op(1'b1, TOP, 16'h3333, 1'b1, 1'b0, "R8 no access");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R8");
      op(1'b0, TOP, 16'h0, 1'b0, 1'b0, "R8");
      op(1'b1, TOP, 16'h0001, 1'b1, 1'b0, "R8");
      op(1'b1, OTHER, 16'h3C3C, 1'b1, 1'b0, "R8 foreign fourth");
      regs_chk("R8");
      load_pattern(16'h0001, 16'h1357, "R8 fresh");
   endtask

   task automatic t_pulse_r10();
      load_pattern(16'h0000, 16'h00F0, "R10");
      @(negedge clk);
      chk("R10 hit falls", cfg_hit, 1'b0);
      chk("R10 load falls", cfg_load, 1'b0);
      regs_chk("R10 hold");
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset_r1();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_load_rfr_r2();
      t_load_bus_r3();
      t_read_back_r4();
      t_dpd_r9();
      t_lockout_r5();
      t_we_ctrl_r6();
      t_bad_sel_r7();
      t_other_r8();
      t_pulse_r10();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule